// File: doc/BRIEF.md
# MII Management Frame Register with Embedded PHY Register Model

This block gives a host a single 32-bit register through which whole MII management frames are issued. The host writes one word. The block decodes the start code, opcode, PHY address and register address from that word, and the access is finished at the next clock edge. No serial management signalling takes place. The target of the access is an embedded model of a 32-entry, 16-bit PHY register file. This model reproduces the side effects of the control register, follows a link-up input, and reports link changes through a clear-on-read event register.

Next to the frame register, a configuration register carries two bits that software cannot write. An event output is raised while the event register is non-zero. Host reads are combinational: `rdata_o` shows the selected register in the same cycle as `rd_en_i`. A read of the event register clears it at that clock edge. `link_up_i` is assumed to be synchronous to `clk_i`.

Top module: `mii_mgmt_unit`

## Requirements
- R1: The frame word is decoded as start [31:30], opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16] and data [15:0]. After any write to the frame register (host offset 0x0C), bit 16 of the stored value reads 1.
- R2: With start 01, PHY address equal to `PHY_ADDR` (default 1) and opcode 01, the data field is written into the addressed PHY register, and the frame register stores the written word with bit 16 set.
- R3: With start 01, the matching PHY address and opcode 10, the frame register stores bits 31:17 of the written word, then bit 16 = 1, then the addressed PHY register's contents in bits 15:0.
- R4: When the start code is not 01, the PHY address does not match, or the opcode is 00 or 11, no PHY register changes, and the frame register stores the written word with bit 16 set.
- R5: A write to PHY register 0 with bit 15 set stores the data with bit 15 cleared and bit 12 set.
- R6: A write to PHY register 0 with bit 9 set stores the data with bit 9 cleared and sets bit 5 of PHY register 1. If `link_up_i` is 1 at that time, it also sets bit 2 of register 1 and bit 8 of register 5.
- R7: The configuration register (host offset 0x10) resets to 0x00000100. A write leaves bits 9:8 unchanged and stores all other bits.
- R8: A change of `link_up_i` makes bit 2 of register 1 and bit 8 of register 5 equal to the new level one cycle later. It also sets the 16-bit event register (host offset 0x18) to 0xFFFF. `event_o` is 1 exactly while that register is non-zero.
- R9: A read of the event register clears it. If a link change occurs in the same cycle, the register is set to 0xFFFF instead.
- R10: After reset: frame register is 0; event register is 0; register 4 = 0x0100; registers 2 and 3 = `ID_HI`/`ID_LO`; register 1 = 0x4028; all other PHY registers are 0. One cycle after reset is released, bit 2 of register 1 and bit 8 of register 5 follow `link_up_i`, and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Link level seen by the PHY model |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe (clears event register when it is selected) |
| addr_i | input | 5 | Host byte offset |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data for `addr_i`, valid in the same cycle |
| event_o | output | 1 | Event register non-zero |

## Verification
On every cycle, the assertions check four things: the completion bit after each frame write, that the read-only configuration bits hold across writes, that the self-clearing control bits never remain stored, and that the event register is loaded and cleared correctly around link changes and reads. Other behaviours can only be shown by the bench's scenarios, because they depend on sequences of accesses: the control-register side effects seen through later read frames, the silence of rejected frames, the state after reset and after the first cycle following reset, and the contents of the whole register file after a random mix of accesses.

// File: rtl/mii_mgmt_pkg.sv
`timescale 1ns/1ps
package mii_mgmt_pkg;
  localparam int FRAME_W = 32;
  localparam int PHY_DW  = 16;
  localparam int PHY_AW  = 5;
  localparam int HOST_AW = 5;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_RSV  = 2'b11
  } mii_op_e;

  // bit order of this struct is the frame layout
  typedef struct packed {
    logic [1:0]        start;
    mii_op_e           opc;
    logic [4:0]        phy_ad;
    logic [PHY_AW-1:0] reg_ad;
    logic [1:0]        turn;
    logic [PHY_DW-1:0] data;
  } mii_frame_t;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam int DONE_BIT = 16;

  localparam logic [HOST_AW-1:0] OFS_FRAME = 5'h0C;
  localparam logic [HOST_AW-1:0] OFS_CFG   = 5'h10;
  localparam logic [HOST_AW-1:0] OFS_EVT   = 5'h18;

  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_ID_H = 2;
  localparam int IDX_ID_L = 3;
  localparam int IDX_ADV  = 4;
  localparam int IDX_LPA  = 5;

  localparam int CTRL_RST  = 15;
  localparam int CTRL_ANEN = 12;
  localparam int CTRL_ANRS = 9;
  localparam int STAT_ANOK = 5;
  localparam int STAT_LINK = 2;
  localparam int ABIL_TXFD = 8;

  localparam logic [PHY_DW-1:0] ADV_RST  = 16'h0100;
  localparam logic [PHY_DW-1:0] STAT_RST = 16'h4028;
  localparam logic [31:0]       CFG_RST  = 32'h0000_0100;
  localparam logic [31:0]       CFG_RO   = 32'h0000_0300;
endpackage

// File: rtl/mii_frame_dec.sv
`timescale 1ns/1ps
module mii_frame_dec
  import mii_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic [FRAME_W-1:0] frame_i,
  output logic               hit_wr_o,
  output logic               hit_rd_o,
  output logic [PHY_AW-1:0]  reg_o,
  output logic [PHY_DW-1:0]  data_o
);
  mii_frame_t f;
  logic       ok;

  assign f        = mii_frame_t'(frame_i);
  assign ok       = (f.start == START_CODE) && (f.phy_ad == PHY_ADDR);
  assign hit_wr_o = ok && (f.opc == OP_WR);
  assign hit_rd_o = ok && (f.opc == OP_RD);
  assign reg_o    = f.reg_ad;
  assign data_o   = f.data;
endmodule

// File: rtl/mii_link_mon.sv
`timescale 1ns/1ps
module mii_link_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  output logic prime_o,
  output logic chg_o
);
  logic link_q, primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      link_q   <= link_i;
      primed_q <= 1'b1;
    end
  end

  assign prime_o = !primed_q;
  assign chg_o   = primed_q && (link_i != link_q);
endmodule

// File: rtl/mii_phy_regs.sv
`timescale 1ns/1ps
module mii_phy_regs
  import mii_mgmt_pkg::*;
#(
  parameter int                NREG  = 32,
  parameter logic [PHY_DW-1:0] ID_HI = 16'h2000,
  parameter logic [PHY_DW-1:0] ID_LO = 16'h5C01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PHY_AW-1:0] waddr_i,
  input  logic [PHY_DW-1:0] wdata_i,
  input  logic [PHY_AW-1:0] raddr_i,
  output logic [PHY_DW-1:0] rdata_o,
  input  logic              link_i,
  input  logic              link_load_i,
  output logic [PHY_DW-1:0] ctrl_o,
  output logic [PHY_DW-1:0] stat_o
);
  localparam int IW = $clog2(NREG);

  logic [PHY_DW-1:0] mem_q [NREG];
  logic [PHY_DW-1:0] mem_d [NREG];
  logic [PHY_DW-1:0] wval;

  function automatic logic [PHY_DW-1:0] rst_val(input int idx);
    case (idx)
      IDX_STAT: rst_val = STAT_RST;
      IDX_ID_H: rst_val = ID_HI;
      IDX_ID_L: rst_val = ID_LO;
      IDX_ADV:  rst_val = ADV_RST;
      default:  rst_val = '0;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < NREG; i++) mem_d[i] = mem_q[i];
    wval = wdata_i;
    if (wr_i) begin
      if (waddr_i == PHY_AW'(IDX_CTRL)) begin
        if (wval[CTRL_RST]) begin
          wval[CTRL_RST]  = 1'b0;
          wval[CTRL_ANEN] = 1'b1;
        end
        if (wval[CTRL_ANRS]) begin
          wval[CTRL_ANRS] = 1'b0;
          mem_d[IDX_STAT][STAT_ANOK] = 1'b1;
          if (link_i) begin
            mem_d[IDX_STAT][STAT_LINK] = 1'b1;
            mem_d[IDX_LPA][ABIL_TXFD]  = 1'b1;
          end
        end
      end
      mem_d[IW'(waddr_i)] = wval;
    end
    // link level applied last: it wins over a same-cycle host write
    if (link_load_i) begin
      mem_d[IDX_STAT][STAT_LINK] = link_i;
      mem_d[IDX_LPA][ABIL_TXFD]  = link_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= rst_val(i);
    end else begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rdata_o = mem_q[IW'(raddr_i)];
  assign ctrl_o  = mem_q[IDX_CTRL];
  assign stat_o  = mem_q[IDX_STAT];
endmodule

// File: rtl/mii_mgmt_unit.sv
`timescale 1ns/1ps
module mii_mgmt_unit
  import mii_mgmt_pkg::*;
#(
  parameter logic [4:0]        PHY_ADDR = 5'd1,
  parameter logic [PHY_DW-1:0] ID_HI    = 16'h2000,
  parameter logic [PHY_DW-1:0] ID_LO    = 16'h5C01
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               link_up_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [FRAME_W-1:0] wdata_i,
  output logic [FRAME_W-1:0] rdata_o,
  output logic               event_o
);
  localparam int NREG = 1 << PHY_AW;

  logic [FRAME_W-1:0] frame_q, cfg_q;
  logic [PHY_DW-1:0]  evt_q;
  logic               wr_frame, wr_cfg, rd_evt;
  logic               hit_wr, hit_rd;
  logic [PHY_AW-1:0]  reg_a;
  logic [PHY_DW-1:0]  wr_data, phy_rd, ctrl_q, stat_q;
  logic               link_prime, link_chg;

  assign wr_frame = wr_en_i && (addr_i == OFS_FRAME);
  assign wr_cfg   = wr_en_i && (addr_i == OFS_CFG);
  assign rd_evt   = rd_en_i && (addr_i == OFS_EVT);

  mii_frame_dec #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .frame_i (wdata_i),
    .hit_wr_o(hit_wr),
    .hit_rd_o(hit_rd),
    .reg_o   (reg_a),
    .data_o  (wr_data)
  );

  mii_link_mon u_link (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .link_i (link_up_i),
    .prime_o(link_prime),
    .chg_o  (link_chg)
  );

  mii_phy_regs #(.NREG(NREG), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_frame && hit_wr),
    .waddr_i    (reg_a),
    .wdata_i    (wr_data),
    .raddr_i    (reg_a),
    .rdata_o    (phy_rd),
    .link_i     (link_up_i),
    .link_load_i(link_prime || link_chg),
    .ctrl_o     (ctrl_q),
    .stat_o     (stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      cfg_q   <= CFG_RST;
      evt_q   <= '0;
    end else begin
      if (wr_frame) begin
        if (hit_rd) frame_q <= {wdata_i[FRAME_W-1:DONE_BIT+1], 1'b1, phy_rd};
        else        frame_q <= wdata_i | (32'd1 << DONE_BIT);
      end
      if (wr_cfg) cfg_q <= (wdata_i & ~CFG_RO) | (cfg_q & CFG_RO);
      if (link_chg)    evt_q <= '1;
      else if (rd_evt) evt_q <= '0;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_FRAME: rdata_o = frame_q;
      OFS_CFG:   rdata_o = cfg_q;
      OFS_EVT:   rdata_o = {{(FRAME_W-PHY_DW){1'b0}}, evt_q};
      default:   rdata_o = '0;
    endcase
  end

  assign event_o = |evt_q;
endmodule

// File: rtl/mii_mgmt_chk.sv
`timescale 1ns/1ps
module mii_mgmt_chk
  import mii_mgmt_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [HOST_AW-1:0] addr_i,
  input logic               link_up_i,
  input logic [FRAME_W-1:0] frame_q,
  input logic [FRAME_W-1:0] cfg_q,
  input logic [PHY_DW-1:0]  evt_q,
  input logic               link_chg,
  input logic [PHY_DW-1:0]  ctrl_q,
  input logic [PHY_DW-1:0]  stat_q
);
  // R1
  frame_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_FRAME) |=> frame_q[DONE_BIT]);

  // R7
  cfg_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_CFG) |=> (cfg_q[9:8] == $past(cfg_q[9:8])));

  // R5
  ctrl_rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CTRL_RST]);

  // R6
  ctrl_restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CTRL_ANRS]);

  // R8
  link_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_chg |=> (evt_q == 16'hFFFF) && (stat_q[STAT_LINK] == $past(link_up_i)));

  // R9
  evt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_EVT && !link_chg) |=> (evt_q == '0));
endmodule

bind mii_mgmt_unit mii_mgmt_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .link_up_i(link_up_i),
  .frame_q  (frame_q),
  .cfg_q    (cfg_q),
  .evt_q    (evt_q),
  .link_chg (link_chg),
  .ctrl_q   (ctrl_q),
  .stat_q   (stat_q)
);

// File: tb/sim_mii_mgmt_unit.sv
`timescale 1ns/1ps
module sim_mii_mgmt_unit;
  localparam logic [15:0] ID_HI = 16'h2000;
  localparam logic [15:0] ID_LO = 16'h5C01;
  localparam logic [4:0] A_FRAME = 5'h0C;
  localparam logic [4:0] A_CFG   = 5'h10;
  localparam logic [4:0] A_EVT   = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        evt_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] phy_m [32];
  logic [15:0] evt_m;
  logic        link_m;

  always #2.5 clk = ~clk;

  mii_mgmt_unit #(.PHY_ADDR(5'd1), .ID_HI(ID_HI), .ID_LO(ID_LO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .link_up_i(link), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .event_o(evt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
    if (a == A_EVT) evt_m = '0;
  endtask

  function automatic logic valid_f(input logic [31:0] f);
    return f[31:30] == 2'b01 && f[27:23] == 5'd1;
  endfunction

  function automatic logic [31:0] exp_frame(input logic [31:0] f);
    if (valid_f(f) && f[29:28] == 2'b10)
      return {f[31:17], 1'b1, phy_m[f[22:18]]};
    return f | 32'h0001_0000;
  endfunction

  task automatic model_wr(input logic [4:0] r, input logic [15:0] d);
    logic [15:0] v = d;
    if (r == 5'd0) begin
      if (v[15]) begin v[15] = 1'b0; v[12] = 1'b1; end
      if (v[9]) begin
        v[9] = 1'b0;
        phy_m[1][5] = 1'b1;
        if (link_m) begin phy_m[1][2] = 1'b1; phy_m[5][8] = 1'b1; end
      end
    end
    phy_m[r] = v;
  endtask

  task automatic mdio(input string tag, input logic [31:0] f);
    logic [31:0] got, exp;
    exp = exp_frame(f);
    bus_wr(A_FRAME, f);
    if (valid_f(f) && f[29:28] == 2'b01) model_wr(f[22:18], f[15:0]);
    bus_rd(A_FRAME, got);
    chk(tag, got, exp);
  endtask

  function automatic logic [31:0] fr(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] pa, input logic [4:0] ra,
                                     input logic [15:0] d);
    return {st, op, pa, ra, 2'b00, d};
  endfunction

  task automatic phy_chk(input string tag, input logic [4:0] r);
    mdio(tag, fr(2'b01, 2'b10, 5'd1, r, 16'h0));
  endtask

  task automatic set_link(input logic v);
    @(negedge clk); link = v;
    @(negedge clk);
    if (v != link_m) begin
      phy_m[1][2] = v; phy_m[5][8] = v; evt_m = 16'hFFFF;
    end
    link_m = v;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7321));
    for (int i = 0; i < 32; i++) phy_m[i] = 16'h0;
    phy_m[1] = 16'h402C; phy_m[2] = ID_HI; phy_m[3] = ID_LO;
    phy_m[4] = 16'h0100; phy_m[5] = 16'h0100;
    evt_m = '0; link_m = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 reset state
    bus_rd(A_FRAME, d); chk("R10 frame reset", d, 32'h0);
    bus_rd(A_CFG, d);   chk("R7 cfg reset", d, 32'h0000_0100);
    bus_rd(A_EVT, d);   chk("R10 no event after priming", d, 32'h0);
    chk("R10 event_o", {31'd0, evt_o}, 32'd0);
    for (int r = 0; r < 8; r++) phy_chk("R10 phy reset / R3 read", 5'(r));

    // R7 read-only config bits
    bus_wr(A_CFG, 32'hFFFF_FCFF); bus_rd(A_CFG, d); chk("R7 ro kept", d, 32'hFFFF_FDFF);
    bus_wr(A_CFG, 32'h0000_0000); bus_rd(A_CFG, d); chk("R7 ro kept 0", d, 32'h0000_0100);

    // R5 reset bit
    mdio("R5 write", fr(2'b01, 2'b01, 5'd1, 5'd0, 16'h8000));
    phy_chk("R5 ctrl", 5'd0);

    // R8 link down
    set_link(1'b0);
    chk("R8 event_o", {31'd0, evt_o}, 32'd1);
    phy_chk("R8 stat link", 5'd1);
    phy_chk("R8 partner", 5'd5);
    bus_rd(A_EVT, d); chk("R8 evt ffff", d, 32'h0000_FFFF);
    bus_rd(A_EVT, d); chk("R9 clear on read", d, 32'h0);
    chk("R9 event_o low", {31'd0, evt_o}, 32'd0);

    // R6 restart with link down, then up
    mdio("R2 clear stat", fr(2'b01, 2'b01, 5'd1, 5'd1, 16'h0));
    mdio("R6 restart", fr(2'b01, 2'b01, 5'd1, 5'd0, 16'h0200));
    phy_chk("R6 ctrl", 5'd0); phy_chk("R6 stat down", 5'd1); phy_chk("R6 lpa down", 5'd5);
    set_link(1'b1);
    bus_rd(A_EVT, d); chk("R8 evt up", d, 32'h0000_FFFF);
    mdio("R2 clear stat", fr(2'b01, 2'b01, 5'd1, 5'd1, 16'h0));
    mdio("R2 clear lpa", fr(2'b01, 2'b01, 5'd1, 5'd5, 16'h0));
    mdio("R6 restart up", fr(2'b01, 2'b01, 5'd1, 5'd0, 16'h8200));
    phy_chk("R6 ctrl up", 5'd0); phy_chk("R6 stat up", 5'd1); phy_chk("R6 lpa up", 5'd5);

    // R4 rejected frames
    mdio("R4 bad start", fr(2'b11, 2'b01, 5'd1, 5'd7, 16'hABCD));
    mdio("R4 bad phy", fr(2'b01, 2'b01, 5'd2, 5'd7, 16'hABCD));
    mdio("R4 opcode 11", fr(2'b01, 2'b11, 5'd1, 5'd7, 16'hABCD));
    mdio("R4 bad phy read", fr(2'b01, 2'b10, 5'd0, 5'd7, 16'h1357));
    phy_chk("R4 reg untouched", 5'd7);

    // R9 set wins over same-cycle clear
    @(negedge clk); rd_en = 1'b1; addr = A_EVT; link = 1'b0;
    @(negedge clk); rd_en = 1'b0;
    phy_m[1][2] = 1'b0; phy_m[5][8] = 1'b0; link_m = 1'b0;
    bus_rd(A_EVT, d); chk("R9 set wins", d, 32'h0000_FFFF);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 9);
      logic [4:0] r = (k < 2) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 7));
      logic [15:0] v = 16'($urandom);
      if (k < 4)      mdio("R2 rand write", fr(2'b01, 2'b01, 5'd1, r, v));
      else if (k < 8) mdio("R3 rand read", fr(2'b01, 2'b10, 5'd1, r, v));
      else if (k < 9) mdio("R4 rand reject", fr(2'($urandom_range(0, 3)), 2'b01,
                                                 5'($urandom_range(2, 31)), r, v));
      else begin
        set_link(~link_m);
        chk("R8 rand event_o", {31'd0, evt_o}, {31'd0, evt_m != 0});
        bus_rd(A_EVT, d); chk("R9 rand evt", d, 32'h0000_FFFF);
      end
    end
    for (int r = 0; r < 32; r++) phy_chk("R2 final regfile", 5'(r));

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule